// File: doc/BRIEF.md
# SD Single-Line Data Phase Checker

This block watches the data line of an SD/MMC transfer in one-bit mode and flags the errors that can occur while data moves across it. A caller pulses `start` with a direction. After that, each sampled line bit is presented on `dat_in`, qualified by `dat_strobe`. The block latches the block length and the three timeout limits at `start` and handles one block per start.

In the card-to-host direction, the block waits for a start bit and then runs a CRC16 over the payload and the 16 check bits that follow it. It then samples the closing bit. In the host-to-card direction, it waits for the card's three-bit CRC status token and judges the token and its closing bit. It then times the busy period, during which the card holds the line low.

Every result appears as a one-cycle pulse, one clock after the strobe that caused it. All timeouts count strobes, not clocks.

Top module: `sd_dat_checker`

## Requirements
- R1: After reset, and while no transfer has been started, all four outputs stay 0 even when strobed bits arrive.
- R2: In read mode (`write_mode`=0), a received block is a 0 start bit, then `blk_bytes` bytes MSB first, then 16 CRC bits MSB first, then one end bit. If the CRC16 (polynomial x^16+x^12+x^5+1, initial value 0) over the payload differs from the received check bits, `crc_err` pulses.
- R3: In read mode, a 0 sampled at the end-bit position pulses `end_err`.
- R4: In read mode, if `rd_timeout` strobes of 1 arrive before the start bit, `timeout_err` pulses on the last of them, `done` does not pulse, and the block returns to idle. A start bit on an earlier strobe is accepted.
- R5: In read mode, `done` pulses on the end-bit strobe of every block that was framed, together with any error from R2 or R3.
- R6: In write mode (`write_mode`=1), the block waits for a 0 start bit and takes the next three bits, MSB first, as the status token. Any token other than 3'b010 pulses `crc_err`.
- R7: In write mode, the bit after the token is the end bit. If it is sampled as 0, `end_err` pulses.
- R8: In write mode, if `tok_timeout` strobes of 1 arrive before the token start bit, `timeout_err` pulses and `done` does not.
- R9: After the write end bit, busy is the line held at 0. If `busy_timeout` strobes of 0 arrive in a row, `timeout_err` pulses on the last of them and `done` does not pulse.
- R10: In write mode, the first strobe with the line at 1 after the end bit ends busy and pulses `done`. This happens even when busy lasted zero strobes.
- R11: Every output pulse lasts one clock and occurs only in the clock after a strobe. `done` and `timeout_err` never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one transfer; accepted only when idle |
| write_mode | input | 1 | 1 = host-to-card token/busy check, 0 = card-to-host block check |
| blk_bytes | input | BLEN_W | Payload length in bytes for read mode |
| rd_timeout | input | TO_W | Strobe limit waiting for a read start bit |
| tok_timeout | input | TO_W | Strobe limit waiting for the status token start bit |
| busy_timeout | input | TO_W | Strobe limit for the busy period |
| dat_strobe | input | 1 | Qualifies `dat_in` as one sampled line bit |
| dat_in | input | 1 | Sampled data line level |
| crc_err | output | 1 | Pulse: payload CRC mismatch or bad status token |
| end_err | output | 1 | Pulse: end bit sampled as 0 |
| timeout_err | output | 1 | Pulse: start bit or busy release did not arrive in time |
| done | output | 1 | Pulse: transfer finished |

## Verification
A corrupted CRC register or a wrong bit counter shows up at the end-bit strobe of the same block. It appears as a `crc_err` that should not be there, or as `done` landing on the wrong strobe, or as no `done` at all. An off-by-one in either timeout counter moves `timeout_err` onto the wrong strobe, or turns an expected `done` into a timeout. The bench catches this by sweeping start-bit delays and busy lengths through each limit. A state machine stuck outside idle shows up on the next transfer as missing pulses. Because every transfer is checked by counting the pulses it produces, this is seen within one transfer.

// File: rtl/sd_dat_checker.sv
module sd_dat_checker #(
  parameter int BLEN_W = 10,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              write_mode,
  input  logic [BLEN_W-1:0] blk_bytes,
  input  logic [TO_W-1:0]   rd_timeout,
  input  logic [TO_W-1:0]   tok_timeout,
  input  logic [TO_W-1:0]   busy_timeout,
  input  logic              dat_strobe,
  input  logic              dat_in,
  output logic              crc_err,
  output logic              end_err,
  output logic              timeout_err,
  output logic              done
);
  localparam int BC_W = BLEN_W + 3;
  localparam logic [15:0] POLY = 16'h1021;
  localparam logic [2:0]  TOK_OK = 3'b010;

  typedef enum logic [3:0] {
    S_IDLE, S_RWAIT, S_RDATA, S_RCRC, S_REND,
    S_WWAIT, S_WTOK, S_WEND, S_WBUSY
  } state_t;

  state_t            state;
  logic [BC_W-1:0]   bitcnt;
  logic [BLEN_W-1:0] blen_q;
  logic [TO_W-1:0]   rto_q, tto_q, bto_q;
  logic [TO_W:0]     tcnt;
  logic [15:0]       crc;
  logic [2:0]        tok;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic d);
    crc_step = {c[14:0], 1'b0} ^ ((c[15] ^ d) ? POLY : 16'h0000);
  endfunction

  logic [TO_W-1:0] lim;
  logic [TO_W:0]   tnext;
  logic            hit;
  logic            last_data;

  assign lim       = (state == S_RWAIT) ? rto_q : (state == S_WWAIT) ? tto_q : bto_q;
  assign tnext     = tcnt + 1'b1;
  assign hit       = tnext >= {1'b0, lim};
  assign last_data = bitcnt == ({blen_q, 3'b000} - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      bitcnt      <= '0;
      blen_q      <= '0;
      rto_q       <= '0;
      tto_q       <= '0;
      bto_q       <= '0;
      tcnt        <= '0;
      crc         <= '0;
      tok         <= '0;
      crc_err     <= 1'b0;
      end_err     <= 1'b0;
      timeout_err <= 1'b0;
      done        <= 1'b0;
    end else begin
      crc_err     <= 1'b0;
      end_err     <= 1'b0;
      timeout_err <= 1'b0;
      done        <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          blen_q <= blk_bytes;
          rto_q  <= rd_timeout;
          tto_q  <= tok_timeout;
          bto_q  <= busy_timeout;
          tcnt   <= '0;
          state  <= write_mode ? S_WWAIT : S_RWAIT;
        end
        S_RWAIT: if (dat_strobe) begin
          if (!dat_in) begin
            crc    <= '0;
            bitcnt <= '0;
            state  <= (blen_q == '0) ? S_RCRC : S_RDATA;
          end else if (hit) begin
            timeout_err <= 1'b1;
            state       <= S_IDLE;
          end else begin
            tcnt <= tnext;
          end
        end
        S_RDATA: if (dat_strobe) begin
          crc <= crc_step(crc, dat_in);
          if (last_data) begin
            bitcnt <= '0;
            state  <= S_RCRC;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        S_RCRC: if (dat_strobe) begin
          crc    <= crc_step(crc, dat_in);
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == BC_W'(15)) state <= S_REND;
        end
        S_REND: if (dat_strobe) begin
          crc_err <= crc != 16'h0000;
          end_err <= !dat_in;
          done    <= 1'b1;
          state   <= S_IDLE;
        end
        S_WWAIT: if (dat_strobe) begin
          if (!dat_in) begin
            bitcnt <= '0;
            state  <= S_WTOK;
          end else if (hit) begin
            timeout_err <= 1'b1;
            state       <= S_IDLE;
          end else begin
            tcnt <= tnext;
          end
        end
        S_WTOK: if (dat_strobe) begin
          tok    <= {tok[1:0], dat_in};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == BC_W'(2)) state <= S_WEND;
        end
        S_WEND: if (dat_strobe) begin
          crc_err <= tok != TOK_OK;
          end_err <= !dat_in;
          tcnt    <= '0;
          state   <= S_WBUSY;
        end
        S_WBUSY: if (dat_strobe) begin
          if (dat_in) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (hit) begin
            timeout_err <= 1'b1;
            state       <= S_IDLE;
          end else begin
            tcnt <= tnext;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_dat_checker_chk.sv
module sd_dat_checker_chk (
  input logic clk,
  input logic rst_n,
  input logic dat_strobe,
  input logic crc_err,
  input logic end_err,
  input logic timeout_err,
  input logic done
);
  AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err || end_err || timeout_err || done) |-> $past(dat_strobe)); // R11
  AST_DONE_XOR_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout_err)); // R11
  AST_CRC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |=> !crc_err); // R2
  AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_err |=> !end_err); // R3
  AST_TIMEOUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> !timeout_err); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_TIMEOUT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> !(crc_err || end_err)); // R4
endmodule

bind sd_dat_checker sd_dat_checker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dat_strobe(dat_strobe),
  .crc_err(crc_err), .end_err(end_err), .timeout_err(timeout_err), .done(done)
);

// File: tb/sim_sd_dat_checker.sv
module sim_sd_dat_checker;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 3;

  logic clk = 0, rst_n = 0, start = 0, write_mode = 0;
  logic [9:0]  blk_bytes = 10'd1;
  logic [15:0] rd_timeout = 16'(LIM), tok_timeout = 16'(LIM), busy_timeout = 16'(LIM);
  logic dat_strobe = 0, dat_in = 1;
  logic crc_err, end_err, timeout_err, done;

  int checks = 0, errors = 0;
  int n_crc = 0, n_end = 0, n_to = 0, n_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_dat_checker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .write_mode(write_mode),
    .blk_bytes(blk_bytes), .rd_timeout(rd_timeout), .tok_timeout(tok_timeout),
    .busy_timeout(busy_timeout), .dat_strobe(dat_strobe), .dat_in(dat_in),
    .crc_err(crc_err), .end_err(end_err), .timeout_err(timeout_err), .done(done)
  );

  always @(negedge clk) begin
    if (crc_err) n_crc++;
    if (end_err) n_end++;
    if (timeout_err) n_to++;
    if (done) n_done++;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    @(posedge clk);
    n_crc = 0; n_end = 0; n_to = 0; n_done = 0;
  endtask

  task automatic bitx(input logic b);
    @(negedge clk); dat_in = b; dat_strobe = 1;
    @(negedge clk); dat_strobe = 0; dat_in = 1;
  endtask

  task automatic kick(input logic wm, input int nbytes);
    @(negedge clk); start = 1; write_mode = wm; blk_bytes = 10'(nbytes);
    @(negedge clk); start = 0;
  endtask

  task automatic expect4(input string tag, input int c, input int e, input int t, input int d);
    repeat (3) @(negedge clk);
    check({tag, " crc_err"}, n_crc, c);
    check({tag, " end_err"}, n_end, e);
    check({tag, " timeout_err"}, n_to, t);
    check({tag, " done"}, n_done, d);
    clear_counts();
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic run_read(input int nbytes, input int seed, input int idle_hi,
                          input int flip, input int endb);
    logic [15:0] c = 16'h0000;
    kick(0, nbytes);
    for (int k = 0; k < idle_hi; k++) bitx(1'b1);
    if (idle_hi >= LIM) begin
      expect4("R4 read timeout", 0, 0, 1, 0);
      return;
    end
    bitx(1'b0);
    for (int i = 0; i < nbytes; i++) begin
      for (int b = 7; b >= 0; b--) begin
        logic d = pat(seed, i)[b];
        bitx(d);
        c = ((c << 1) & 16'hFFFF) ^ (((c >> 15) & 16'h1) != 16'(d) ? 16'h1021 : 16'h0000);
      end
    end
    for (int b = 15; b >= 0; b--) bitx(c[b] ^ ((flip != 0) && (b == seed % 16)));
    bitx(1'(endb));
    expect4(flip != 0 ? "R2 R5 read crc" : (endb == 0 ? "R3 R5 read end" : "R5 read ok"),
            flip, endb == 0 ? 1 : 0, 0, 1);
  endtask

  task automatic run_write(input int idle_hi, input int tok, input int endb, input int busy_lo);
    kick(1, 1);
    for (int k = 0; k < idle_hi; k++) bitx(1'b1);
    if (idle_hi >= LIM) begin
      expect4("R8 token timeout", 0, 0, 1, 0);
      return;
    end
    bitx(1'b0);
    for (int b = 2; b >= 0; b--) bitx(1'((tok >> b) & 1));
    bitx(1'(endb));
    for (int k = 0; k < busy_lo && k < LIM; k++) bitx(1'b0);
    if (busy_lo < LIM) bitx(1'b1);
    expect4(busy_lo >= LIM ? "R9 busy timeout" :
            (tok != 2 ? "R6 R10 token" : (endb == 0 ? "R7 R10 end" : "R10 busy done")),
            tok != 2 ? 1 : 0, endb == 0 ? 1 : 0,
            busy_lo >= LIM ? 1 : 0, busy_lo >= LIM ? 0 : 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset crc_err", int'(crc_err), 0);
    check("R1 reset done", int'(done), 0);
    for (int k = 0; k < 6; k++) bitx(1'(k & 1));
    expect4("R1 idle strobes", 0, 0, 0, 0);

    for (int n = 1; n <= 4; n++)
      for (int s = 0; s < 3; s++)
        for (int f = 0; f < 2; f++)
          for (int e = 0; e < 2; e++)
            run_read(n, s, 0, f, e);
    for (int h = 0; h <= LIM + 1; h++) run_read(2, h, h, 0, 1);

    for (int t = 0; t < 8; t++)
      for (int e = 0; e < 2; e++)
        for (int b = 0; b <= LIM + 1; b++)
          run_write(0, t, e, b);
    for (int h = 0; h <= LIM + 1; h++) run_write(h, 2, 1, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule